// File: doc/BRIEF.md
# Overcurrent Retry Controller

This block watches two H-bridge power stages for overcurrent and decides when their gate enables are removed and restored. Each bridge delivers one current-limit-active flag per FET and one flag that says its sense voltage is over threshold. All of these flags are already synchronous to the block clock. A current-limit flag only counts as a fault once it has stayed high longer than a deglitch window. A sense-over-threshold flag counts as soon as it is seen.

When a bridge faults, its enable output drops and the active-low fault output goes low. A static mode input selects the scope of the shutdown. In global mode any fault shuts down every bridge. In per-bridge mode only the faulting bridge shuts down and the others keep driving.

Once the retry interval has passed, the disabled bridges are enabled again and the fault output is released. A fault that persists through re-enable starts the shutdown again. While a bridge is disabled, its inputs are blanked.

Top module: `ocp_retry_ctrl`

## Requirements
- R1: A per-FET current-limit flag trips its bridge on the rising clock edge at which it has been sampled high on DEGLITCH_CYC+1 consecutive edges (4 with defaults). A run of DEGLITCH_CYC or fewer edges causes no trip.
- R2: A bridge whose sense-over-threshold flag is sampled high on any rising edge while the bridge is enabled trips on that edge.
- R3: With `global_mode_i` = 1, a trip on any bridge drives every `bridge_en_o` bit low from the edge of the trip.
- R4: With `global_mode_i` = 0, only the tripping bridge's enable goes low, and the other bridges stay enabled. Bit b of `bridge_en_o` and of `sense_ov_i` belongs to bridge b. Bit b*FETS_PER_BRIDGE+f of `ilim_i` belongs to FET f of bridge b.
- R5: A tripped bridge's enable stays low for exactly RETRY_CYC clock cycles (64 by default) and then returns high.
- R6: `fault_no` is low on every cycle in which at least one bridge is disabled by a trip, and high otherwise. In per-bridge mode it therefore stays low until the last retrying bridge is enabled again.
- R7: While `rst_ni` is low, all enables are high, `fault_no` is high and all timers are cleared. This also holds when reset arrives in the middle of a retry interval.
- R8: Each FET's deglitch count restarts from zero whenever its flag is sampled low. The counts of different FETs are independent, so alternating short pulses on two FETs never trip.
- R9: Flags of a disabled bridge are ignored. Neither sense nor current-limit activity during the retry interval shortens, restarts or extends it.
- R10: If the overcurrent condition persists, the bridge is disabled again after re-enable. With a persistent sense flag this happens after one enabled cycle. With a persistent current-limit flag it happens after DEGLITCH_CYC+1 enabled cycles, because deglitch counting starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| global_mode_i | input | 1 | 1: any trip disables all bridges; 0: only the faulting bridge |
| ilim_i | input | NUM_BRIDGES*FETS_PER_BRIDGE | Per-FET current-limit-active flags |
| sense_ov_i | input | NUM_BRIDGES | Per-bridge sense-voltage-over-threshold flags |
| bridge_en_o | output | NUM_BRIDGES | Per-bridge gate enable, 1 = bridge may drive |
| fault_no | output | 1 | Active-low overcurrent fault indication |

## Verification
The hardest situations to reach are those where two timelines overlap. One is a second bridge tripping partway through the first bridge's retry interval in per-bridge mode. The other is fault activity arriving on a bridge that is already disabled. The stimulus reaches them by counting clock edges from a single-cycle sense pulse, injecting the second event at a known edge, and then checking the enable and fault outputs at the exact edges where each interval should end. Persistent faults are held across the whole retry interval so that the re-enable window can be measured in cycles.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    BR_RUN  = 1'b0,
    BR_HOLD = 1'b1
  } br_state_e;
endpackage

// File: rtl/ocp_deglitch.sv
module ocp_deglitch #(
  parameter int DEGLITCH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ilim_i,
  output logic trip_o
);
  localparam int CW = (DEGLITCH_CYC < 1) ? 1 : $clog2(DEGLITCH_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEGLITCH_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !ilim_i)  cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  // qualified on the sample after DEGLITCH_CYC consecutive highs
  assign trip_o = ilim_i && !clr_i && (cnt_q == CNT_MAX);

  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ilim_i || clr_i) |=> (cnt_q == '0));
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/ocp_bridge_monitor.sv
module ocp_bridge_monitor #(
  parameter int FETS_PER_BRIDGE = 4,
  parameter int DEGLITCH_CYC    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       active_i,
  input  logic [FETS_PER_BRIDGE-1:0] ilim_i,
  input  logic                       sense_ov_i,
  output logic                       trip_o
);
  logic [FETS_PER_BRIDGE-1:0] fet_trip;

  for (genvar f = 0; f < FETS_PER_BRIDGE; f++) begin : g_fet
    ocp_deglitch #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_dg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!active_i),
      .ilim_i (ilim_i[f]),
      .trip_o (fet_trip[f])
    );
  end

  // detection blanked while the bridge is held off
  assign trip_o = active_i && ((|fet_trip) || sense_ov_i);

  p_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !trip_o);
  p_sense_trip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && sense_ov_i) |-> trip_o);
endmodule

// File: rtl/ocp_retry_timer.sv
module ocp_retry_timer
  import ocp_pkg::*;
#(
  parameter int RETRY_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shut_i,
  output logic en_o,
  output logic retry_o
);
  localparam int TW = (RETRY_CYC < 2) ? 1 : $clog2(RETRY_CYC);
  localparam logic [TW-1:0] LOAD = TW'(RETRY_CYC - 1);

  br_state_e state_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BR_RUN;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        BR_RUN: if (shut_i) begin
          state_q <= BR_HOLD;
          tmr_q   <= LOAD;
        end
        BR_HOLD: begin
          if (tmr_q == '0) state_q <= BR_RUN;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= BR_RUN;
      endcase
    end
  end

  assign en_o    = (state_q == BR_RUN);
  assign retry_o = (state_q == BR_HOLD);

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_i && state_q == BR_RUN) |=> (!en_o && tmr_q == LOAD));
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BR_HOLD && tmr_q == '0) |=> en_o);
  p_no_early_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BR_HOLD && tmr_q != '0) |=> !en_o);
endmodule

// File: rtl/ocp_retry_ctrl.sv
module ocp_retry_ctrl #(
  parameter int NUM_BRIDGES     = 2,
  parameter int FETS_PER_BRIDGE = 4,
  parameter int DEGLITCH_CYC    = 3,
  parameter int RETRY_CYC       = 64
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   global_mode_i,
  input  logic [NUM_BRIDGES*FETS_PER_BRIDGE-1:0] ilim_i,
  input  logic [NUM_BRIDGES-1:0]                 sense_ov_i,
  output logic [NUM_BRIDGES-1:0]                 bridge_en_o,
  output logic                                   fault_no
);
  logic [NUM_BRIDGES-1:0] trip;
  logic [NUM_BRIDGES-1:0] shut;
  logic [NUM_BRIDGES-1:0] retry;
  logic                   any_trip;

  assign any_trip = |trip;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    ocp_bridge_monitor #(
      .FETS_PER_BRIDGE (FETS_PER_BRIDGE),
      .DEGLITCH_CYC    (DEGLITCH_CYC)
    ) u_mon (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .active_i   (bridge_en_o[b]),
      .ilim_i     (ilim_i[b*FETS_PER_BRIDGE +: FETS_PER_BRIDGE]),
      .sense_ov_i (sense_ov_i[b]),
      .trip_o     (trip[b])
    );

    assign shut[b] = global_mode_i ? any_trip : trip[b];

    ocp_retry_timer #(.RETRY_CYC(RETRY_CYC)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shut_i  (shut[b]),
      .en_o    (bridge_en_o[b]),
      .retry_o (retry[b])
    );

    p_local_trip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip[b] |=> !bridge_en_o[b]);
  end

  assign fault_no = ~|retry;

  p_global_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (global_mode_i && any_trip) |=> (bridge_en_o == '0));
  p_fault_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_trip |=> !fault_no);
  p_fault_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bridge_en_o) |-> fault_no);
endmodule

// File: tb/ocp_retry_ctrl_tb_top.sv
`timescale 1ns/1ps
module ocp_retry_ctrl_tb_top;
  localparam int  NB = 2;
  localparam int  NF = 4;
  localparam int  DG = 3;
  localparam int  RT = 64;
  localparam real HALF = 2.5;

  typedef struct packed {
    logic          mode;
    logic [NB*NF-1:0] ilim;
    logic [NB-1:0] sense;
    logic [7:0]    ncyc;
    logic [NB-1:0] exp_en;
    logic          exp_f;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h01, 2'b00, 8'd3, 2'b11, 1'b1},
    '{1'b0, 8'h01, 2'b00, 8'd4, 2'b10, 1'b0},
    '{1'b1, 8'h02, 2'b00, 8'd4, 2'b00, 1'b0},
    '{1'b0, 8'h00, 2'b10, 8'd1, 2'b01, 1'b0},
    '{1'b1, 8'h00, 2'b10, 8'd1, 2'b00, 1'b0},
    '{1'b0, 8'h80, 2'b00, 8'd4, 2'b01, 1'b0},
    '{1'b0, 8'h00, 2'b11, 8'd1, 2'b00, 1'b0},
    '{1'b1, 8'h30, 2'b00, 8'd3, 2'b11, 1'b1}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R1";
      1: return "R1/R4";
      2: return "R3";
      3: return "R2/R4";
      4: return "R2/R3";
      5: return "R4";
      6: return "R2";
      default: return "R1/R3";
    endcase
  endfunction

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic global_mode_i = 1'b0;
  logic [NB*NF-1:0] ilim_i = '0;
  logic [NB-1:0] sense_ov_i = '0;
  logic [NB-1:0] bridge_en_o;
  logic fault_no;

  int n_chk = 0;
  int n_fail = 0;

  always #(HALF) clk_i = ~clk_i;

  ocp_retry_ctrl #(
    .NUM_BRIDGES(NB), .FETS_PER_BRIDGE(NF), .DEGLITCH_CYC(DG), .RETRY_CYC(RT)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .global_mode_i(global_mode_i),
    .ilim_i(ilim_i), .sense_ov_i(sense_ov_i),
    .bridge_en_o(bridge_en_o), .fault_no(fault_no)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk_i);
    rst_ni = 1'b0;
    global_mode_i = mode;
    ilim_i = '0;
    sense_ov_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // counts negedges on which bridge b stays low, starting at the current one
  task automatic measure_low(input int b, output int n_low, output int f_err);
    n_low = 0;
    f_err = 0;
    while (bridge_en_o[b] == 1'b0 && n_low < 4*RT) begin
      n_low++;
      if (fault_no !== 1'b0) f_err++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    n_fail++;
    $display("FAIL all watchdog expired");
    summary();
  end

  initial begin
    int n_low, f_err, n_hi;

    // R7: reset state
    repeat (2) @(negedge clk_i);
    chk("R7", "en in reset", 32'(bridge_en_o), 32'h3);
    chk("R7", "fault in reset", 32'(fault_no), 32'h1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].mode);
      ilim_i = VECS[i].ilim;
      sense_ov_i = VECS[i].sense;
      repeat (int'(VECS[i].ncyc)) @(negedge clk_i);
      chk(vec_req(i), $sformatf("vec%0d en", i), 32'(bridge_en_o), 32'(VECS[i].exp_en));
      chk(vec_req(i), $sformatf("vec%0d fault", i), 32'(fault_no), 32'(VECS[i].exp_f));
      ilim_i = '0;
      sense_ov_i = '0;
    end

    // R5/R6: retry length, other bridge runs
    do_reset(1'b0);
    sense_ov_i = 2'b01;
    @(negedge clk_i);
    sense_ov_i = '0;
    chk("R4", "other bridge enabled", 32'(bridge_en_o[1]), 32'h1);
    measure_low(0, n_low, f_err);
    chk("R5", "retry cycles", 32'(n_low), 32'(RT));
    chk("R6", "fault low during retry", 32'(f_err), 32'h0);
    chk("R6", "fault released", 32'(fault_no), 32'h1);

    // R3/R5: global mode, both return together
    do_reset(1'b1);
    sense_ov_i = 2'b10;
    @(negedge clk_i);
    sense_ov_i = '0;
    n_low = 0;
    while (bridge_en_o == 2'b00 && n_low < 4*RT) begin
      n_low++;
      @(negedge clk_i);
    end
    chk("R3", "global retry cycles", 32'(n_low), 32'(RT));
    chk("R3", "both back", 32'(bridge_en_o), 32'h3);

    // R8: deglitch restart and per-FET independence
    do_reset(1'b0);
    ilim_i = 8'h01; repeat (3) @(negedge clk_i);
    ilim_i = 8'h00; @(negedge clk_i);
    ilim_i = 8'h01; repeat (3) @(negedge clk_i);
    ilim_i = 8'h00; @(negedge clk_i);
    chk("R8", "restart no trip", 32'(bridge_en_o), 32'h3);
    for (int k = 0; k < 6; k++) begin
      ilim_i = (k % 2 == 0) ? 8'h01 : 8'h02;
      repeat (2) @(negedge clk_i);
    end
    ilim_i = '0;
    chk("R8", "alternating FETs no trip", 32'(bridge_en_o), 32'h3);

    // R9: activity during retry ignored
    do_reset(1'b0);
    sense_ov_i = 2'b01;
    @(negedge clk_i);
    sense_ov_i = '0;
    repeat (19) @(negedge clk_i);
    sense_ov_i = 2'b01;
    ilim_i = 8'h0F;
    repeat (10) @(negedge clk_i);
    sense_ov_i = '0;
    ilim_i = '0;
    measure_low(0, n_low, f_err);
    chk("R9", "retry not altered", 32'(n_low + 29), 32'(RT));
    chk("R9", "enabled after retry", 32'(bridge_en_o), 32'h3);

    // R6: overlapping per-bridge retries
    do_reset(1'b0);
    sense_ov_i = 2'b01;
    @(negedge clk_i);          // E1
    sense_ov_i = '0;
    repeat (9) @(negedge clk_i);   // E10
    sense_ov_i = 2'b10;
    @(negedge clk_i);          // E11
    sense_ov_i = '0;
    chk("R4", "both in retry", 32'(bridge_en_o), 32'h0);
    repeat (54) @(negedge clk_i);  // E65
    chk("R5", "bridge0 back", 32'(bridge_en_o), 32'h1);
    chk("R6", "fault held by bridge1", 32'(fault_no), 32'h0);
    repeat (10) @(negedge clk_i);  // E75
    chk("R6", "all back", 32'(bridge_en_o), 32'h3);
    chk("R6", "fault released", 32'(fault_no), 32'h1);

    // R10: persistent sense
    do_reset(1'b0);
    sense_ov_i = 2'b01;
    @(negedge clk_i);
    measure_low(0, n_low, f_err);
    chk("R10", "first retry", 32'(n_low), 32'(RT));
    @(negedge clk_i);
    chk("R10", "sense retrips", 32'(bridge_en_o[0]), 32'h0);
    sense_ov_i = '0;

    // R10: persistent current limit
    do_reset(1'b0);
    ilim_i = 8'h01;
    repeat (4) @(negedge clk_i);
    measure_low(0, n_low, f_err);
    n_hi = 0;
    while (bridge_en_o[0] == 1'b1 && n_hi < 4*RT) begin
      n_hi++;
      @(negedge clk_i);
    end
    chk("R10", "enabled window", 32'(n_hi), 32'(DG + 1));
    ilim_i = '0;

    // R7: async reset during retry
    do_reset(1'b0);
    sense_ov_i = 2'b11;
    @(negedge clk_i);
    sense_ov_i = '0;
    repeat (5) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    chk("R7", "reset mid retry en", 32'(bridge_en_o), 32'h3);
    chk("R7", "reset mid retry fault", 32'(fault_no), 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R7", "stays enabled", 32'(bridge_en_o), 32'h3);

    summary();
  end
endmodule